// File: doc/BRIEF.md
# PCI Express Root Port Configuration Register File

This block holds the configuration space that a PCI Express root port presents to software: a 64-byte type 1 bridge header at byte offsets 0x00 to 0x3C, followed at 0x40 by the basic PCI Express capability structure, which ends with the root status dword at 0x60. A simple single-beat register port reaches every dword. It has a write strobe with byte enables and a read strobe. Read data is registered and comes back one cycle after the strobe. Every bit has one of four behaviours: software-writable, read-only, write-one-to-clear, or reserved. Reserved bits read zero and ignore writes. The read-only values come from parameters or from live hardware inputs. Dedicated event inputs set the error and status flags, and software later clears them by writing ones.

The masks follow root-port rules. Bits that only make sense on conventional PCI, on endpoints or on upstream ports are treated as reserved. The expansion ROM dword, both base address dwords and the slot dwords read as zero. The capability structure reports a root port whose version comes from an input, and the status register always advertises a capability list. The access path is a two-state machine. In `ST_IDLE` no read response is pending. In `ST_RESP` the response register holds valid data. `req_rd` moves the machine from `ST_IDLE` to `ST_RESP`, and keeps it in `ST_RESP` when reads come back to back. A cycle without `req_rd` returns it to `ST_IDLE`. A write is performed in the cycle its strobe is seen.

Top module: `rp_cfg_space`

## Requirements
- R1: After reset every writable and write-one-to-clear bit is 0, `rsp_valid` is 0, `rsp_rdata` is 0, and the identity dwords read their parameter values: 0x00 holds {device, vendor} and 0x08 holds {class code, revision}.
- R2: A read strobe makes `rsp_valid` high exactly one cycle later, with the dword at `req_addr[ADDR_W-1:2]`. The value returned is the one from before any write in the same cycle. Dword indices 25 and above read 0. `rsp_valid` is 0 in a cycle that follows no read.
- R3: A write changes only writable bits in the bytes whose `req_be` bit is 1. `req_be[n]` covers data bits 8n+7:8n. The bridge window dwords 0x20 to 0x30 are writable, except for the read-only low nibbles at 0x20 and 0x24. 0x24 reports 64-bit prefetchable addressing (0x0001_0001).
- R4: Writing 1 to a write-one-to-clear bit clears it, and writing 0 leaves it unchanged. When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set.
- R5: The expansion ROM dword 0x38, the base address dwords 0x10 and 0x14 and the slot dwords 0x54 and 0x58 always read 0, whatever is written to them.
- R6: Status bit 20 of dword 0x04 (capability list) always reads 1, and dword 0x34 bits 7:0 read 0x40.
- R7: Dword 0x40 reads capability ID 0x10 in bits 7:0 and next pointer 0 in bits 15:8. Bits 19:16 hold `cfg_cap_ver`, which must be 1 or 2. Bits 23:20 hold 4 (root port). Bit 24 (slot) and bit 31 are 0. The whole dword is read-only.
- R8: At dword 0x48, bits 14:0 are writable and bit 15 is reserved. Bits 19:16 are write-one-to-clear and are set by `hw_dev_err[3:0]`. Bits 21:20 follow `hw_dev_flags`. Bits 31:22 read 0.
- R9: At dword 0x50, the writable mask is 0x0000_CEFB (link control bit 8 is reserved). Bits 29:16 follow `hw_link_info`. Bits 31:30 are write-one-to-clear and are set by `hw_link_evt[1:0]`.
- R10: Dword 0x44 reads `DEVCAP_VAL & 0x0000_803F`. Dword 0x4C reads `LINKCAP_VAL` with bits 23 and 18 forced to 0. Both ignore writes.
- R11: Bits used only by conventional PCI are reserved. At 0x04 the command write mask is 0x0547. Status bits 21, 23, 25 and 26 read 0. Status bits 24 and 31:27 are write-one-to-clear, set by `hw_pri_err` with bit 0 going to bit 24 and bits 5:1 going to bits 31:27. At 0x0C, bits 7:0 are writable, bits 15:8 and 31:24 read 0, and bits 23:16 read 0x01. At 0x18, bits 31:24 are reserved and bits 23:0 are writable. At 0x3C, bits 7:0 and the bridge-control bits 20:16 and 22 are writable, and bits 15:8 read `INT_PIN`.
- R12: At dword 0x5C, bits 4:0 are writable and bit 16 reads `ROOT_CRS_VIS`. At dword 0x60, bits 15:0 follow `hw_pme_rid` and bit 17 follows `hw_pme_pending`. Bit 16 is write-one-to-clear and is set by `hw_pme_evt`.
- R13: At dword 0x1C, the writable mask is 0x0000_F0F0 and bits 11:8 and 3:0 read 0x1 each. Secondary status bits 24 and 31:27 are write-one-to-clear, set by `hw_sec_err` with the same bit mapping as `hw_pri_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cap_ver | input | 4 | Capability version reported at 0x40 (1 or 2) |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe |
| req_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| req_be | input | 4 | Write byte enables |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after `req_rd` |
| rsp_rdata | output | 32 | Read data |
| hw_pri_err | input | 6 | Set pulses for the primary status error flags |
| hw_sec_err | input | 6 | Set pulses for the secondary status error flags |
| hw_dev_err | input | 4 | Set pulses for the device status error flags |
| hw_dev_flags | input | 2 | Live device status bits 21:20 |
| hw_link_info | input | 14 | Live link status bits 29:16 |
| hw_link_evt | input | 2 | Set pulses for the link bandwidth event flags |
| hw_pme_evt | input | 1 | Set pulse for the PME status flag |
| hw_pme_rid | input | 16 | Live PME requester ID |
| hw_pme_pending | input | 1 | Live PME pending flag |

## Verification
A wrong mask or a wrong stored bit shows up only when that dword is read. The error appears in the read data one cycle after the strobe, and it stays visible until a later write or event repairs the bit. A lost event or a clear that lands on the wrong bit leaves a status flag in the wrong state, and every later read of that dword shows it. A reserved bit that gets stored would come back as 1 after a write of all ones. For that reason the random phase keeps writing wide patterns, raising events and reading every dword, including indices past the implemented range, and compares each read with a bench model.

// File: rtl/rp_cfg_pkg.sv
package rp_cfg_pkg;

    localparam int HDR_DWORDS  = 16;
    localparam int CAP_DWORDS  = 9;
    localparam int CAP_BASE_DW = HDR_DWORDS;
    localparam int TOTAL_DW    = HDR_DWORDS + CAP_DWORDS;
    localparam logic [7:0] CAP_START_BYTE = 8'(CAP_BASE_DW * 4);

    typedef struct packed {
        logic [31:0] rw;
        logic [31:0] ro;
        logic [31:0] w1c;
    } dw_policy_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } acc_state_e;

    // Per-dword access masks for a root port; bits in no mask are reserved.
    function automatic dw_policy_t policy_of(input int unsigned idx);
        dw_policy_t p;
        p = '0;
        case (idx)
            0:  p.ro = 32'hFFFF_FFFF;
            1: begin
                p.rw  = 32'h0000_0547;
                p.ro  = 32'h0010_0000;
                p.w1c = 32'hF900_0000;
            end
            2:  p.ro = 32'hFFFF_FFFF;
            3: begin
                p.rw = 32'h0000_00FF;
                p.ro = 32'h00FF_0000;
            end
            4, 5: p.ro = 32'hFFFF_FFFF;
            6:  p.rw = 32'h00FF_FFFF;
            7: begin
                p.rw  = 32'h0000_F0F0;
                p.ro  = 32'h0000_0F0F;
                p.w1c = 32'hF900_0000;
            end
            8, 9: begin
                p.rw = 32'hFFF0_FFF0;
                p.ro = 32'h000F_000F;
            end
            10, 11, 12: p.rw = 32'hFFFF_FFFF;
            13: p.ro = 32'h0000_00FF;
            14: p.ro = 32'hFFFF_FFFF;
            15: begin
                p.rw = 32'h005F_00FF;
                p.ro = 32'h0000_FF00;
            end
            16: p.ro = 32'h7FFF_FFFF;
            17: p.ro = 32'h0000_803F;
            18: begin
                p.rw  = 32'h0000_7FFF;
                p.ro  = 32'h0030_0000;
                p.w1c = 32'h000F_0000;
            end
            19: p.ro = 32'hFF7B_FFFF;
            20: begin
                p.rw  = 32'h0000_CEFB;
                p.ro  = 32'h3FFF_0000;
                p.w1c = 32'hC000_0000;
            end
            23: begin
                p.rw = 32'h0000_001F;
                p.ro = 32'h0001_0000;
            end
            24: begin
                p.ro  = 32'h0002_FFFF;
                p.w1c = 32'h0001_0000;
            end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/rp_cfg_dword.sv
module rp_cfg_dword #(
    parameter logic [31:0] RW_MASK  = 32'h0,
    parameter logic [31:0] W1C_MASK = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_hit,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    input  logic [31:0] hw_set,
    output logic [31:0] q
);
    localparam logic [31:0] KEEP_MASK = RW_MASK | W1C_MASK;

    logic [31:0] byte_mask;
    logic [31:0] wr_bits;
    logic [31:0] clr_bits;
    logic [31:0] after_wr;
    logic [31:0] q_next;

    always_comb begin
        byte_mask = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
        wr_bits   = wr_hit ? (byte_mask & RW_MASK) : 32'h0;
        clr_bits  = wr_hit ? (byte_mask & W1C_MASK & wdata) : 32'h0;
        after_wr  = (q & ~wr_bits) | (wdata & wr_bits);
        q_next    = ((after_wr & ~clr_bits) | (hw_set & W1C_MASK)) & KEEP_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= 32'h0;
        else        q <= q_next;
    end

    // R4: a hardware set wins over a same-cycle software clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & W1C_MASK)) |=> ((q & $past(hw_set & W1C_MASK)) == $past(hw_set & W1C_MASK)));

    // R4: writing zeros never clears a set flag
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ((wdata & W1C_MASK) == 32'h0))
        |=> ((q & $past(q & W1C_MASK)) == $past(q & W1C_MASK)));

    // R3: a write with no byte enabled and no event leaves the dword alone
    a_r3_no_be_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (be == 4'b0000) && ((hw_set & W1C_MASK) == 32'h0)) |=> $stable(q));

endmodule

// File: rtl/rp_cfg_access_fsm.sv
module rp_cfg_access_fsm
    import rp_cfg_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int NUM_DW = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [31:0]       rd_mux,
    output logic [NUM_DW-1:0] wr_sel,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata
);
    acc_state_e state_q;
    acc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_rd ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_rd ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_rdata <= 32'h0;
        else if (req_rd) rsp_rdata <= rd_mux;
    end

    assign rsp_valid = (state_q == ST_RESP);

    always_comb begin
        for (int i = 0; i < NUM_DW; i++) begin
            wr_sel[i] = req_wr && (req_idx == IDX_W'(i));
        end
    end

    // R2: response valid exactly one cycle after each read strobe
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_rd |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rd |=> !rsp_valid);
    // R3: at most one dword takes a write
    a_r3_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

endmodule

// File: rtl/rp_cfg_space.sv
module rp_cfg_space
    import rp_cfg_pkg::*;
#(
    parameter int          ADDR_W       = 12,
    parameter logic [15:0] VENDOR_ID    = 16'h1E5A,
    parameter logic [15:0] DEVICE_ID    = 16'h0C31,
    parameter logic [7:0]  REV_ID       = 8'h01,
    parameter logic [23:0] CLASS_CODE   = 24'h060400,
    parameter logic [7:0]  INT_PIN      = 8'h01,
    parameter logic [31:0] DEVCAP_VAL   = 32'h0000_8002,
    parameter logic [31:0] LINKCAP_VAL  = 32'h0000_0C12,
    parameter logic        ROOT_CRS_VIS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cfg_cap_ver,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    input  logic [5:0]        hw_pri_err,
    input  logic [5:0]        hw_sec_err,
    input  logic [3:0]        hw_dev_err,
    input  logic [1:0]        hw_dev_flags,
    input  logic [13:0]       hw_link_info,
    input  logic [1:0]        hw_link_evt,
    input  logic              hw_pme_evt,
    input  logic [15:0]       hw_pme_rid,
    input  logic              hw_pme_pending
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NUM_DW = TOTAL_DW;
    localparam int DW_CMD = 1, DW_SECSTS = 7, DW_ROM = 14, DW_EXPCAP = CAP_BASE_DW;
    localparam int DW_DEVCTL = CAP_BASE_DW + 2, DW_LNKCTL = CAP_BASE_DW + 4;
    localparam int DW_ROOTSTS = CAP_BASE_DW + 8;
    localparam logic [IDX_W-1:0] ROM_IDX  = IDX_W'(DW_ROM);
    localparam logic [IDX_W-1:0] CMD_IDX  = IDX_W'(DW_CMD);
    localparam logic [IDX_W-1:0] CAP_IDX  = IDX_W'(DW_EXPCAP);
    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(NUM_DW);

    logic [IDX_W-1:0] req_idx;
    logic             unused_addr_lo;
    logic [31:0]      q_arr   [NUM_DW];
    logic [31:0]      ro_val  [NUM_DW];
    logic [31:0]      set_arr [NUM_DW];
    logic [31:0]      rd_word [NUM_DW];
    logic [31:0]      rd_mux;
    logic [NUM_DW-1:0] wr_sel;

    assign req_idx        = req_addr[ADDR_W-1:2];
    assign unused_addr_lo = ^req_addr[1:0];

    // Read-only source values; the policy masks select which bits show.
    always_comb begin
        for (int k = 0; k < NUM_DW; k++) ro_val[k] = 32'h0;
        ro_val[0]          = {DEVICE_ID, VENDOR_ID};
        ro_val[DW_CMD]     = 32'h0010_0000;
        ro_val[2]          = {CLASS_CODE, REV_ID};
        ro_val[3]          = 32'h0001_0000;
        ro_val[DW_SECSTS]  = 32'h0000_0101;
        ro_val[9]          = 32'h0001_0001;
        ro_val[13]         = {24'h0, CAP_START_BYTE};
        ro_val[15]         = {16'h0, INT_PIN, 8'h00};
        ro_val[DW_EXPCAP]  = {8'h00, 4'h4, cfg_cap_ver, 8'h00, 8'h10};
        ro_val[CAP_BASE_DW + 1] = DEVCAP_VAL;
        ro_val[DW_DEVCTL]  = {10'h0, hw_dev_flags, 20'h0};
        ro_val[CAP_BASE_DW + 3] = LINKCAP_VAL;
        ro_val[DW_LNKCTL]  = {2'b00, hw_link_info, 16'h0};
        ro_val[CAP_BASE_DW + 7] = {15'h0, ROOT_CRS_VIS, 16'h0};
        ro_val[DW_ROOTSTS] = {14'h0, hw_pme_pending, 1'b0, hw_pme_rid};
    end

    // Hardware event routing onto write-one-to-clear positions.
    always_comb begin
        for (int k = 0; k < NUM_DW; k++) set_arr[k] = 32'h0;
        set_arr[DW_CMD]     = {hw_pri_err[5:1], 2'b00, hw_pri_err[0], 24'h0};
        set_arr[DW_SECSTS]  = {hw_sec_err[5:1], 2'b00, hw_sec_err[0], 24'h0};
        set_arr[DW_DEVCTL]  = {12'h0, hw_dev_err, 16'h0};
        set_arr[DW_LNKCTL]  = {hw_link_evt, 30'h0};
        set_arr[DW_ROOTSTS] = {15'h0, hw_pme_evt, 16'h0};
    end

    for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
        localparam dw_policy_t POL = policy_of(i);
        rp_cfg_dword #(
            .RW_MASK  (POL.rw),
            .W1C_MASK (POL.w1c)
        ) u_dw (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_sel[i]),
            .be     (req_be),
            .wdata  (req_wdata),
            .hw_set (set_arr[i]),
            .q      (q_arr[i])
        );
        assign rd_word[i] = q_arr[i] | (ro_val[i] & POL.ro);
    end

    always_comb begin
        rd_mux = 32'h0;
        for (int i = 0; i < NUM_DW; i++) begin
            if (req_idx == IDX_W'(i)) rd_mux = rd_word[i];
        end
    end

    rp_cfg_access_fsm #(
        .IDX_W  (IDX_W),
        .NUM_DW (NUM_DW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_rd    (req_rd),
        .req_wr    (req_wr),
        .req_idx   (req_idx),
        .rd_mux    (rd_mux),
        .wr_sel    (wr_sel),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // R5: the expansion ROM dword always answers zero
    a_r5_rom_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_idx == ROM_IDX) |=> (rsp_rdata == 32'h0));
    // R6: capability list flag always advertised
    a_r6_cap_list: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_idx == CMD_IDX) |=> rsp_rdata[20]);
    // R7: capability header reports a root port with no slot
    a_r7_port_type: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_idx == CAP_IDX)
        |=> (rsp_rdata[23:20] == 4'h4 && !rsp_rdata[24] && !rsp_rdata[31] && rsp_rdata[7:0] == 8'h10));
    // R7: only versions 1 and 2 are legal
    a_r7_ver_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cap_ver == 4'd1 || cfg_cap_ver == 4'd2));
    // R2: dwords past the capability read zero
    a_r2_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && req_idx >= END_IDX) |=> (rsp_rdata == 32'h0));

endmodule

// File: tb/sim_rp_cfg_space.sv
module sim_rp_cfg_space;
    localparam logic [15:0] VEN = 16'h1B4E;
    localparam logic [15:0] DEV = 16'h7A21;
    localparam logic [7:0]  REV = 8'h03;
    localparam logic [23:0] CLS = 24'h060400;
    localparam logic [7:0]  IPIN = 8'h01;
    localparam logic [31:0] DCAP = 32'hFFFF_FFFF;
    localparam logic [31:0] LCAP = 32'hFFFF_FFFF;
    localparam logic        CRS = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] cfg_cap_ver = 4'd2;
    logic req_wr = 0, req_rd = 0;
    logic [11:0] req_addr = '0;
    logic [3:0] req_be = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [5:0] hw_pri_err = '0, hw_sec_err = '0;
    logic [3:0] hw_dev_err = '0;
    logic [1:0] hw_dev_flags = 2'b10;
    logic [13:0] hw_link_info = 14'h1041;
    logic [1:0] hw_link_evt = '0;
    logic hw_pme_evt = 1'b0;
    logic [15:0] hw_pme_rid = 16'h0300;
    logic hw_pme_pending = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [31:0] mst [0:33];

    always #4 clk = ~clk;

    rp_cfg_space #(
        .ADDR_W(12), .VENDOR_ID(VEN), .DEVICE_ID(DEV), .REV_ID(REV), .CLASS_CODE(CLS),
        .INT_PIN(IPIN), .DEVCAP_VAL(DCAP), .LINKCAP_VAL(LCAP), .ROOT_CRS_VIS(CRS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_cap_ver(cfg_cap_ver), .req_wr(req_wr), .req_rd(req_rd),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .hw_pri_err(hw_pri_err), .hw_sec_err(hw_sec_err),
        .hw_dev_err(hw_dev_err), .hw_dev_flags(hw_dev_flags), .hw_link_info(hw_link_info),
        .hw_link_evt(hw_link_evt), .hw_pme_evt(hw_pme_evt), .hw_pme_rid(hw_pme_rid),
        .hw_pme_pending(hw_pme_pending)
    );

    function automatic logic [31:0] m_rw(input int k);
        case (k)
            1: return 32'h0000_0547;   3: return 32'h0000_00FF;
            6: return 32'h00FF_FFFF;   7: return 32'h0000_F0F0;
            8, 9: return 32'hFFF0_FFF0; 10, 11, 12: return 32'hFFFF_FFFF;
            15: return 32'h005F_00FF;  18: return 32'h0000_7FFF;
            20: return 32'h0000_CEFB;  23: return 32'h0000_001F;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_w1c(input int k);
        case (k)
            1, 7: return 32'hF900_0000; 18: return 32'h000F_0000;
            20: return 32'hC000_0000;   24: return 32'h0001_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_ro(input int k);
        case (k)
            0: return {DEV, VEN};
            1: return 32'h0010_0000;
            2: return {CLS, REV};
            3: return 32'h0001_0000;
            7: return 32'h0000_0101;
            9: return 32'h0001_0001;
            13: return 32'h0000_0040;
            15: return {16'h0, IPIN, 8'h00};
            16: return {8'h00, 4'h4, cfg_cap_ver, 16'h0010};
            17: return DCAP & 32'h0000_803F;
            18: return {10'h0, hw_dev_flags, 20'h0};
            19: return LCAP & 32'hFF7B_FFFF;
            20: return {2'b00, hw_link_info, 16'h0};
            23: return {15'h0, CRS, 16'h0};
            24: return {14'h0, hw_pme_pending, 1'b0, hw_pme_rid};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_set(input int k);
        case (k)
            1: return {hw_pri_err[5:1], 2'b00, hw_pri_err[0], 24'h0};
            7: return {hw_sec_err[5:1], 2'b00, hw_sec_err[0], 24'h0};
            18: return {12'h0, hw_dev_err, 16'h0};
            20: return {hw_link_evt, 30'h0};
            24: return {15'h0, hw_pme_evt, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            0, 2: return "R1 identity";
            1, 3, 6, 15: return "R11 header";
            4, 5, 14, 21, 22: return "R5 zero dword";
            7: return "R13 io/secondary";
            8, 9, 10, 11, 12: return "R3 window";
            13: return "R6 cap pointer";
            16: return "R7 cap header";
            17, 19: return "R10 capabilities";
            18: return "R8 device ctl/sts";
            20: return "R9 link ctl/sts";
            23, 24: return "R12 root";
            default: return "R2 out of range";
        endcase
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access cycle; called at a falling edge, returns at the next one.
    task automatic step(input logic wr, input logic rd, input int k, input logic [3:0] be,
                        input logic [31:0] d, output logic [31:0] got);
        logic [31:0] exp, bm, wb, cb;
        req_wr = wr; req_rd = rd; req_addr = 12'(k * 4); req_be = be; req_wdata = d;
        exp = (k < 25) ? (mst[k] | (m_ro(k) & ~(m_rw(k) | m_w1c(k)))) : 32'h0;
        for (int j = 0; j < 25; j++) begin
            bm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
            wb = (wr && j == k) ? (bm & m_rw(j)) : 32'h0;
            cb = (wr && j == k) ? (bm & m_w1c(j) & d) : 32'h0;
            mst[j] = (((mst[j] & ~wb) | (d & wb)) & ~cb) | (m_set(j) & m_w1c(j));
        end
        @(posedge clk);
        @(negedge clk);
        req_wr = 0; req_rd = 0;
        hw_pri_err = '0; hw_sec_err = '0; hw_dev_err = '0; hw_link_evt = '0; hw_pme_evt = 0;
        chk({31'h0, rsp_valid}, {31'h0, rd}, "R2 response valid");
        if (rd) chk(rsp_rdata, exp, tag_of(k));
        got = rsp_rdata;
    endtask

    task automatic wr_only(input int k, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] g;
        step(1'b1, 1'b0, k, be, d, g);
    endtask

    task automatic rd_lit(input int k, input logic [31:0] lit, input string tag);
        logic [31:0] g;
        step(1'b0, 1'b1, k, 4'h0, 32'h0, g);
        chk(g, lit, tag);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] g;
        void'($urandom(32'd20251));
        for (int j = 0; j < 34; j++) mst[j] = 32'h0;
        repeat (3) @(negedge clk);
        chk({31'h0, rsp_valid}, 32'h0, "R1 valid in reset");
        chk(rsp_rdata, 32'h0, "R1 data in reset");
        rst_n = 1'b1;

        rd_lit(0, {DEV, VEN}, "R1 ids");
        rd_lit(2, {CLS, REV}, "R1 class");
        rd_lit(6, 32'h0, "R1 bus numbers cleared");
        rd_lit(1, 32'h0010_0000, "R6 capability list bit");
        rd_lit(13, 32'h0000_0040, "R6 pointer");
        rd_lit(16, 32'h0042_0010, "R7 header v2");
        rd_lit(17, 32'h0000_803F, "R10 devcap");
        rd_lit(19, 32'hFF7B_FFFF, "R10 linkcap");
        rd_lit(40, 32'h0, "R2 out of range");

        wr_only(14, 4'hF, 32'hFFFF_FFFF);  rd_lit(14, 32'h0, "R5 rom ignores write");
        wr_only(4, 4'hF, 32'hFFFF_FFFF);   rd_lit(4, 32'h0, "R5 bar ignores write");
        wr_only(21, 4'hF, 32'hFFFF_FFFF);  rd_lit(21, 32'h0, "R5 slot ignores write");
        wr_only(1, 4'hF, 32'hFFFF_FFFF);   rd_lit(1, 32'h0010_0547, "R11 command mask");
        wr_only(3, 4'hF, 32'hFFFF_FFFF);   rd_lit(3, 32'h0001_00FF, "R11 latency reserved");
        wr_only(15, 4'hF, 32'hFFFF_FFFF);  rd_lit(15, 32'h005F_01FF, "R11 bridge control");
        wr_only(6, 4'b0101, 32'hA5A5_A5A5); rd_lit(6, 32'h00A5_00A5, "R3 byte enables");
        wr_only(9, 4'hF, 32'hFFFF_FFFF);   rd_lit(9, 32'hFFF1_FFF1, "R3 prefetch window");
        wr_only(16, 4'hF, 32'hFFFF_FFFF);  rd_lit(16, 32'h0042_0010, "R7 read-only");

        hw_pri_err = 6'h3F; wr_only(1, 4'h0, 32'h0);
        rd_lit(1, 32'hF910_0547, "R11 primary status set");
        hw_dev_err = 4'hF; wr_only(18, 4'h0, 32'h0);
        rd_lit(18, 32'h002F_0000, "R8 device status set");
        wr_only(18, 4'b0100, 32'h0005_0000); rd_lit(18, 32'h002A_0000, "R4 w1c clears ones");
        wr_only(18, 4'hF, 32'h0000_0000);    rd_lit(18, 32'h002A_0000, "R4 zero keeps");
        hw_dev_err = 4'b0010; wr_only(18, 4'hF, 32'h000A_0000);
        rd_lit(18, 32'h0022_0000, "R4 set wins over clear");
        wr_only(18, 4'hF, 32'h0000_FFFF); rd_lit(18, 32'h0022_7FFF, "R8 control mask");
        wr_only(20, 4'hF, 32'h0000_FFFF); rd_lit(20, 32'h1041_CEFB, "R9 link control mask");
        hw_link_evt = 2'b11; wr_only(20, 4'h0, 32'h0);
        wr_only(20, 4'b1000, 32'h4000_0000); rd_lit(20, 32'h9041_CEFB, "R9 link events");
        wr_only(23, 4'hF, 32'hFFFF_FFFF);  rd_lit(23, 32'h0001_001F, "R12 root control");
        hw_pme_evt = 1'b1; hw_pme_pending = 1'b1; wr_only(24, 4'h0, 32'h0);
        rd_lit(24, 32'h0003_0300, "R12 root status");
        hw_sec_err = 6'h21; wr_only(7, 4'hF, 32'hFFFF_FFFF);
        rd_lit(7, 32'h8100_F1F1, "R13 secondary status");
        cfg_cap_ver = 4'd1;
        rd_lit(16, 32'h0041_0010, "R7 header v1");

        for (int n = 0; n < 4000; n++) begin
            int k;
            logic [31:0] d;
            k = int'($urandom % 34);
            d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            if ($urandom % 6 == 0) begin
                hw_pri_err = 6'($urandom); hw_sec_err = 6'($urandom);
                hw_dev_err = 4'($urandom); hw_link_evt = 2'($urandom);
                hw_pme_evt = 1'($urandom);
            end
            if ($urandom % 50 == 0) begin
                hw_link_info = 14'($urandom); hw_pme_rid = 16'($urandom);
                hw_pme_pending = 1'($urandom); hw_dev_flags = 2'($urandom);
                cfg_cap_ver = ($urandom % 2 == 0) ? 4'd1 : 4'd2;
            end
            step(($urandom % 3) == 0, ($urandom % 2) == 0, k, 4'($urandom), d, g);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule